// File: doc/BRIEF.md
# Per-Channel Exposure Drain Gate Sequencer

This block drives the three exposure-drain gate controls of a trilinear colour line sensor, one each for the red, green and blue arrays. While a drain gate is high, photocurrent from that array is diverted away and not collected. The gate goes high at the moment the transfer gate closes at the end of a line. It drops again at a programmed pixel position during readout. Charge collected from that drop until the next transfer-gate closure forms the line's exposure, so each colour can be balanced on its own.

The block is slaved to an external line timing generator. It receives a one-cycle pulse for the falling edge of the transfer gate, a one-cycle pulse for each readout shift-clock edge, and the current pixel count. Exposure values are written in pixel periods into a shadow register for each channel. A shadow value is copied into use only at a transfer-gate falling edge, so a line is never exposed with a value that was half applied. A bypass input holds every gate low, which gives full exposure on all channels.

Top module: `exposure_gate_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, all gate outputs are low. The shadow and in-use exposure values reset to zero.
- R2: On the cycle after a `tg_fall` pulse, the gate of each channel whose new in-use exposure value is below LINE_LEN is high.
- R3: A high gate of a channel with in-use value v (0 < v < LINE_LEN) goes low on the cycle after a cycle where `shift_edge` is high and `pix_cnt` equals LINE_LEN − v. It never goes low on a cycle without a preceding `shift_edge`, `tg_fall` or `bypass`.
- R4: The three channels are independent. The bit positions are 0 = red, 1 = green and 2 = blue in `gate`. The bit positions in `exp_wr` are the same. In `exp_data`, channel c takes bits [c*EXP_W +: EXP_W].
- R5: An in-use value of zero keeps that gate high from its rise until the next `tg_fall`.
- R6: An in-use value equal to or greater than LINE_LEN keeps that gate low for the whole line, including the cycle after `tg_fall`.
- R7: A write through `exp_wr`/`exp_data` changes only the shadow value. The gate timing of the current line does not change. The new value takes effect at the next `tg_fall`.
- R8: While `bypass` is high, every gate is low from the next cycle on. No gate rises while `bypass` is high.
- R9: A gate only rises on the cycle after a `tg_fall` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tg_fall | input | 1 | One-cycle pulse: transfer gate falling edge (end of line) |
| shift_edge | input | 1 | One-cycle pulse: readout shift-clock edge |
| pix_cnt | input | PIX_W | Current pixel position in the line, 0 to LINE_LEN−1 |
| bypass | input | 1 | Hold all gates low (full exposure) |
| exp_wr | input | NCH | Per-channel shadow write strobe |
| exp_data | input | NCH*EXP_W | Packed exposure values in pixel periods |
| gate | output | NCH | Drain gate levels, 1 = drain active |

## Verification
The bench goes after exposure values at the edges of the range. With zero, a design that computes the fall point as LINE_LEN and compares loosely would fall on a wrapped count instead of holding high. With exactly LINE_LEN and with values far above it, a missing clamp would let the subtraction wrap and produce a short exposure where full exposure was asked. With LINE_LEN−1, an off-by-one fall would drop the gate a pixel early or late, and the bench counts high cycles exactly to catch this. A shadow write placed in the middle of a line checks that a single-buffered design, which would shift that line's fall point at once, is caught. Bypass is checked across a whole line to confirm that no gate rises at the transfer edge while it is held.

// File: rtl/exc_pkg.sv
// Shared definitions for the exposure drain gate sequencer.
// Assumes: one package compiled ahead of every exc_* module.
package exc_pkg;

    // Per-channel gate sequence state
    typedef enum logic [1:0] {
        EXC_IDLE  = 2'd0,   // gate low, no line started (reset, full exposure, bypass)
        EXC_DRAIN = 2'd1,   // gate high, photocurrent diverted
        EXC_INTEG = 2'd2    // gate low after fall, charge being collected
    } exc_state_e;

    // Channel index of each colour in the packed ports
    localparam int unsigned EXC_CH_RED   = 0;
    localparam int unsigned EXC_CH_GREEN = 1;
    localparam int unsigned EXC_CH_BLUE  = 2;

endpackage

// File: rtl/exc_shadow.sv
// Double-buffered exposure value for one channel.
// A write lands in the shadow register only. The in-use register takes the
// shadow value on the load pulse (transfer gate falling edge).
// Assumes: wr_en and load are single-cycle, synchronous to clk. If both
// arrive together, the old shadow value is loaded and the write is kept for
// the next line.
module exc_shadow #(
    parameter int unsigned EXP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [EXP_W-1:0] wr_data,
    input  logic             load,
    output logic [EXP_W-1:0] shadow_q,
    output logic [EXP_W-1:0] active_q
);

    // Shadow register: captures software writes at any time
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_en)
            shadow_q <= wr_data;
    end

    // In-use register: updated only at the line boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (load)
            active_q <= shadow_q;
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active_q)); // R7

    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> (active_q == shadow_q)); // R7

endmodule

// File: rtl/exc_fall_calc.sv
// Turns an exposure value in pixel periods into the pixel position where
// the drain gate must fall, clamped to the line.
// Assumes: LINE_LEN fits in PIX_W bits. Purely combinational.
module exc_fall_calc #(
    parameter int unsigned EXP_W    = 8,
    parameter int unsigned LINE_LEN = 40,
    parameter int unsigned PIX_W    = 6
) (
    input  logic [EXP_W-1:0] exp_val,
    output logic [PIX_W-1:0] fall_pt,
    output logic             full_exp,
    output logic             no_exp
);

    localparam int unsigned CW = ((EXP_W > PIX_W) ? EXP_W : PIX_W) + 1;
    localparam logic [CW-1:0] LL = CW'(LINE_LEN);

    logic [CW-1:0] ev_w;
    logic [CW-1:0] diff_w;

    // Clamp: values of LINE_LEN and above give full exposure, zero gives none
    always_comb begin
        ev_w     = CW'(exp_val);
        full_exp = (ev_w >= LL);
        no_exp   = (ev_w == '0);
        diff_w   = full_exp ? '0 : (LL - ev_w);
        fall_pt  = PIX_W'(diff_w);
    end

endmodule

// File: rtl/exc_gate_chan.sv
// Gate sequencer for one colour channel.
// Raises the gate at the transfer gate falling edge and lowers it on the
// shift-clock edge whose pixel count matches the fall point. Bypass holds the
// gate low.
// Assumes: fall_pt and no_exp describe the in-use value. next_full describes
// the value that is loaded at this tg_fall.
module exc_gate_chan
    import exc_pkg::*;
#(
    parameter int unsigned PIX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tg_fall,
    input  logic             shift_edge,
    input  logic [PIX_W-1:0] pix_cnt,
    input  logic             bypass,
    input  logic             next_full,
    input  logic [PIX_W-1:0] fall_pt,
    input  logic             no_exp,
    output logic             gate_o
);

    exc_state_e state_q, state_d;
    logic       hit_fall;

    // Fall condition: a readout edge at the programmed pixel
    always_comb begin
        hit_fall = shift_edge && !no_exp && (pix_cnt == fall_pt);
    end

    // Next-state selection: bypass, then line boundary, then fall point
    always_comb begin
        state_d = state_q;
        if (bypass)
            state_d = EXC_IDLE;
        else if (tg_fall)
            state_d = next_full ? EXC_IDLE : EXC_DRAIN;
        else if (state_q == EXC_DRAIN && hit_fall)
            state_d = EXC_INTEG;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= EXC_IDLE;
        else
            state_q <= state_d;
    end

    // Gate output decoded from state
    always_comb begin
        gate_o = (state_q == EXC_DRAIN);
    end

    AST_RISE_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(tg_fall)); // R9

    AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> ($past(shift_edge) || $past(tg_fall) || $past(bypass))); // R3

    AST_FULL_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tg_fall && next_full) |=> !gate_o); // R6

    AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !gate_o); // R8

    AST_RISE_AFTER_TG: assert property (@(posedge clk) disable iff (!rst_n)
        (tg_fall && !bypass && !next_full) |=> gate_o); // R2

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3); // R1

endmodule

// File: rtl/exposure_gate_ctrl.sv
// Top level: NCH independent exposure drain gate sequencers sharing the line
// timing inputs. Each channel has a double-buffered exposure value, a fall
// point calculation for the in-use value and one for the pending value, and
// a gate state machine.
// Assumes: tg_fall and shift_edge are single-cycle pulses from the line
// timing generator, and pix_cnt stays below LINE_LEN.
module exposure_gate_ctrl #(
    parameter int unsigned NCH      = 3,
    parameter int unsigned EXP_W    = 8,
    parameter int unsigned LINE_LEN = 40,
    parameter int unsigned PIX_W    = $clog2(LINE_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tg_fall,
    input  logic                 shift_edge,
    input  logic [PIX_W-1:0]     pix_cnt,
    input  logic                 bypass,
    input  logic [NCH-1:0]       exp_wr,
    input  logic [NCH*EXP_W-1:0] exp_data,
    output logic [NCH-1:0]       gate
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [EXP_W-1:0] shadow_v;
        logic [EXP_W-1:0] active_v;
        logic [PIX_W-1:0] fall_pt;
        logic [PIX_W-1:0] next_fall_unused;
        logic             full_now_unused;
        logic             no_exp;
        logic             next_full;
        logic             next_none_unused;

        exc_shadow #(.EXP_W(EXP_W)) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (exp_wr[c]),
            .wr_data  (exp_data[c*EXP_W +: EXP_W]),
            .load     (tg_fall),
            .shadow_q (shadow_v),
            .active_q (active_v)
        );

        exc_fall_calc #(.EXP_W(EXP_W), .LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) u_cur (
            .exp_val  (active_v),
            .fall_pt  (fall_pt),
            .full_exp (full_now_unused),
            .no_exp   (no_exp)
        );

        exc_fall_calc #(.EXP_W(EXP_W), .LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) u_next (
            .exp_val  (shadow_v),
            .fall_pt  (next_fall_unused),
            .full_exp (next_full),
            .no_exp   (next_none_unused)
        );

        exc_gate_chan #(.PIX_W(PIX_W)) u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .tg_fall    (tg_fall),
            .shift_edge (shift_edge),
            .pix_cnt    (pix_cnt),
            .bypass     (bypass),
            .next_full  (next_full),
            .fall_pt    (fall_pt),
            .no_exp     (no_exp),
            .gate_o     (gate[c])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (gate == '0)); // R1

endmodule

// File: tb/sim_exposure_gate_ctrl.sv
module sim_exposure_gate_ctrl;
    localparam int NCH = 3;
    localparam int EXP_W = 8;
    localparam int L = 40;
    localparam int PIX_W = $clog2(L + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tg_fall = 1'b0;
    logic shift_edge = 1'b0;
    logic [PIX_W-1:0] pix_cnt = '0;
    logic bypass = 1'b0;
    logic [NCH-1:0] exp_wr = '0;
    logic [NCH*EXP_W-1:0] exp_data = '0;
    logic [NCH-1:0] gate;

    int checks = 0;
    int fails = 0;
    int hi_cnt [NCH];
    logic rise_seen [NCH];

    always #2.5 clk = ~clk;

    exposure_gate_ctrl #(.NCH(NCH), .EXP_W(EXP_W), .LINE_LEN(L)) u0 (
        .clk(clk), .rst_n(rst_n), .tg_fall(tg_fall), .shift_edge(shift_edge),
        .pix_cnt(pix_cnt), .bypass(bypass), .exp_wr(exp_wr),
        .exp_data(exp_data), .gate(gate)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected number of high samples in one line for value v
    function automatic int exp_hi(input int v);
        if (v >= L) return 0;
        if (v == 0) return 2 * L + 1;
        return 2 * (L - v) + 1;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Write shadow values for all channels between lines
    task automatic load3(input int r, input int g, input int b);
        exp_data = {EXP_W'(b), EXP_W'(g), EXP_W'(r)};
        exp_wr = 3'b111;
        step();
        exp_wr = '0;
    endtask

    // One line: tg_fall, then L pixels of two cycles each; optional mid-line write
    task automatic run_line(input logic mid_wr, input int mid_val);
        for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
        tg_fall = 1'b1; shift_edge = 1'b0; pix_cnt = '0;
        step();
        tg_fall = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            rise_seen[c] = gate[c];
            if (gate[c]) hi_cnt[c]++;
        end
        for (int k = 0; k < L; k++) begin
            shift_edge = 1'b1; pix_cnt = PIX_W'(k);
            if (mid_wr && k == 2) begin
                exp_data = {3{EXP_W'(mid_val)}};
                exp_wr = 3'b111;
            end
            step();
            exp_wr = '0;
            for (int c = 0; c < NCH; c++) if (gate[c]) hi_cnt[c]++;
            shift_edge = 1'b0;
            step();
            for (int c = 0; c < NCH; c++) if (gate[c]) hi_cnt[c]++;
        end
    endtask

    task automatic t_reset();
        step(); step();
        check("R1 gates low in reset", int'(gate), 0);
        rst_n = 1'b1;
        step();
        check("R1 gates low after reset", int'(gate), 0);
    endtask

    task automatic t_first_line();
        run_line(1'b0, 0);
        for (int c = 0; c < NCH; c++)
            check("R5 reset value zero keeps gate high", hi_cnt[c], exp_hi(0));
    endtask

    task automatic t_basic();
        int v [NCH] = '{10, 20, 39};
        load3(v[0], v[1], v[2]);
        run_line(1'b0, 0);
        for (int c = 0; c < NCH; c++) begin
            check("R2 rise after tg_fall", int'(rise_seen[c]), 1);
            check("R3 R4 fall position per channel", hi_cnt[c], exp_hi(v[c]));
        end
    endtask

    task automatic t_full();
        load3(40, 200, 1);
        run_line(1'b0, 0);
        check("R6 value equal to line length", hi_cnt[0], 0);
        check("R6 no rise at line length", int'(rise_seen[0]), 0);
        check("R6 value above line length", hi_cnt[1], 0);
        check("R6 no rise above line length", int'(rise_seen[1]), 0);
        check("R3 value one", hi_cnt[2], exp_hi(1));
    endtask

    task automatic t_midwrite();
        load3(5, 5, 5);
        run_line(1'b1, 30);
        for (int c = 0; c < NCH; c++)
            check("R7 mid-line write ignored this line", hi_cnt[c], exp_hi(5));
        run_line(1'b0, 0);
        for (int c = 0; c < NCH; c++)
            check("R7 write applied next line", hi_cnt[c], exp_hi(30));
    endtask

    task automatic t_bypass();
        bypass = 1'b1;
        step();
        check("R8 bypass forces low", int'(gate), 0);
        run_line(1'b0, 0);
        for (int c = 0; c < NCH; c++)
            check("R8 no gate high under bypass", hi_cnt[c], 0);
        bypass = 1'b0;
        run_line(1'b0, 0);
        check("R8 normal after bypass released", hi_cnt[0], exp_hi(30));
    endtask

    initial begin
        t_reset();
        t_first_line();
        t_basic();
        t_full();
        t_midwrite();
        t_bypass();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule